// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block lets a host controller on a two-wire SMBus read and write a small bank of configuration bytes, such as the output-enable and drive settings of a clock generator. Both bus lines are brought in through two-flop synchronisers and sampled on the system clock. START and STOP conditions are recognised as SDA moving while SCL is high. The slave pulls SDA low through an output-enable pin and never drives it high. The register bank is visible to the rest of the chip as one flat vector, and every byte loads a parameterised default on reset.

The first byte after the address is a command byte. Its top bit picks the access type. When the bit is set, the transfer is an indexed single-byte access at the offset held in the low seven bits. When the bit is clear, the transfer is a sequential block access that starts at offset zero. A block write carries a count byte before its data. A block read returns the number of implemented registers before its data. In both block directions the offset advances after every data byte, and the host may end the transfer after any whole byte.

Top module: `smb_cfg_slave`

## Requirements
- R1: During and after reset, `cfg_regs` holds the defaults and `sda_oe` is 0. Byte i of the bank is `cfg_regs[8*i+7:8*i]`, and the defaults are 81h, 24h, 10h, FFh, FFh, 7Eh, 00h, C3h for offsets 0 to 7.
- R2: The first byte after a START is seven address bits followed by the direction bit (1 = read). The slave acknowledges only address 1101001 (write byte D2h, read byte D3h). For any other address it leaves SDA released until the next START.
- R3: Byte write: a command byte with bit 7 = 1 selects the offset in bits 6:0. The following data byte is stored at that offset, and the slave acknowledges the address, the command and the data.
- R4: Byte read: after a byte-mode command and a repeated START carrying the read address, the slave returns the addressed register most significant bit first. The host then sends NACK and STOP.
- R5: Block write: a command byte of 00h is followed by a count byte and then data bytes. The data bytes are stored from offset 0 upward, one offset per byte. Every byte is acknowledged, and bytes written before an early STOP are kept.
- R6: Block read: after a command byte of 00h and a repeated START with the read address, the slave first returns the count 8 and then the registers from offset 0 upward. It continues while the host ACKs and releases SDA after the host NACKs.
- R7: Writes to offsets 8 to 127 leave the bank unchanged, and reads from those offsets return 00h. This applies to indexed access and to block access that runs past the last register.
- R8: `sda_oe` changes only in response to a falling SCL edge or a START/STOP, so the slave never moves SDA while SCL is high during a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_regs | output | NUM_REGS*8 | Register bank, byte i at bits 8*i+7:8*i |

## Verification
A wrong offset pointer or a bad command decode appears on `cfg_regs` one system clock after the falling SCL edge that ends the data byte's eighth bit. It also appears in the serial read data of the next read, where a block read makes a stuck or skipped increment visible within one byte. A wrong state after the address byte appears one SCL low phase later as a missing or unexpected acknowledge. A bit-counter slip shows up as corrupted bits in the data shifted out, and as SDA released or held in the wrong bit slot. The random mix of byte and block operations against a bench-side model of the bank exposes these within a few transactions.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } smb_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_WDATA
  } smb_phase_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;
  logic              scl_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int                    NUM_REGS   = 8,
  parameter int                    ADDR_W     = 7,
  parameter logic [NUM_REGS*8-1:0] RESET_VALS = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_flat
);

  localparam int                IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS);

  logic [7:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        mem[i] <= RESET_VALS[i*8 +: 8];
      end
    end else if (wr_en && (wr_addr < LIMIT)) begin
      mem[wr_addr[IDX_W-1:0]] <= wr_data;
    end
  end

  assign rd_data = (rd_addr < LIMIT) ? mem[rd_addr[IDX_W-1:0]] : 8'h00;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
      assign regs_flat[g*8 +: 8] = mem[g];
    end
  endgenerate

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter int                    NUM_REGS    = 8,
  parameter logic [6:0]            DEV_ADDR    = 7'h69,
  parameter int                    SYNC_STAGES = 2,
  parameter logic [NUM_REGS*8-1:0] RESET_VALS  = 64'hC300_7EFF_FF10_2481
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_regs
);

  localparam int          ADDR_W     = 7;
  localparam logic [7:0]  COUNT_BYTE = 8'(NUM_REGS);
  localparam logic [ADDR_W-1:0] PTR_MAX = '1;

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  smb_state_t        state_q;
  smb_phase_t        phase_q;
  logic [3:0]        bitcnt_q;
  logic [7:0]        shreg_q;
  logic              rd_q;
  logic              blk_q;
  logic              first_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              oe_q;

  logic              wr_en;
  logic [7:0]        rd_data;
  logic [7:0]        tx_byte;
  logic              byte_done;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  smb_reg_bank #(
    .NUM_REGS   (NUM_REGS),
    .ADDR_W     (ADDR_W),
    .RESET_VALS (RESET_VALS)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (ptr_q),
    .wr_data   (shreg_q),
    .rd_addr   (ptr_q),
    .rd_data   (rd_data),
    .regs_flat (cfg_regs)
  );

  assign byte_done = (state_q == ST_RX) && scl_fall && (bitcnt_q == 4'd8);
  assign wr_en     = byte_done && (phase_q == PH_WDATA) && !start_ev && !stop_ev;
  assign tx_byte   = first_q ? COUNT_BYTE : rd_data;
  assign sda_oe    = oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_ADDR;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      rd_q     <= 1'b0;
      blk_q    <= 1'b0;
      first_q  <= 1'b0;
      ptr_q    <= '0;
      oe_q     <= 1'b0;
    end else if (start_ev) begin
      state_q  <= ST_RX;
      phase_q  <= PH_ADDR;
      bitcnt_q <= '0;
      oe_q     <= 1'b0;
    end else if (stop_ev) begin
      state_q  <= ST_IDLE;
      oe_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise && bitcnt_q != 4'd8) begin
            shreg_q  <= {shreg_q[6:0], sda_s};
            bitcnt_q <= bitcnt_q + 4'd1;
          end else if (byte_done) begin
            bitcnt_q <= '0;
            case (phase_q)
              PH_ADDR: begin
                if (shreg_q[7:1] == DEV_ADDR) begin
                  rd_q    <= shreg_q[0];
                  first_q <= blk_q;
                  phase_q <= PH_CMD;
                  oe_q    <= 1'b1;
                  state_q <= ST_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              PH_CMD: begin
                blk_q   <= ~shreg_q[7];
                ptr_q   <= shreg_q[7] ? shreg_q[6:0] : '0;
                phase_q <= shreg_q[7] ? PH_WDATA : PH_CNT;
                oe_q    <= 1'b1;
                state_q <= ST_ACK;
              end
              PH_CNT: begin
                phase_q <= PH_WDATA;
                oe_q    <= 1'b1;
                state_q <= ST_ACK;
              end
              default: begin
                if (blk_q && ptr_q != PTR_MAX) ptr_q <= ptr_q + 7'd1;
                oe_q    <= 1'b1;
                state_q <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt_q <= '0;
            if (rd_q) begin
              shreg_q <= tx_byte;
              oe_q    <= ~tx_byte[7];
              state_q <= ST_TX;
              if (first_q) first_q <= 1'b0;
              else if (blk_q && ptr_q != PTR_MAX) ptr_q <= ptr_q + 7'd1;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt_q == 4'd7) begin
              oe_q    <= 1'b0;
              state_q <= ST_TXACK;
            end else begin
              oe_q     <= ~shreg_q[6];
              shreg_q  <= {shreg_q[6:0], 1'b0};
              bitcnt_q <= bitcnt_q + 4'd1;
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise && sda_s) begin
            state_q <= ST_IDLE;
          end else if (scl_fall) begin
            bitcnt_q <= '0;
            shreg_q  <= tx_byte;
            oe_q     <= ~tx_byte[7];
            state_q  <= ST_TX;
            if (first_q) first_q <= 1'b0;
            else if (blk_q && ptr_q != PTR_MAX) ptr_q <= ptr_q + 7'd1;
          end
        end
        default: begin
          oe_q <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/smb_cfg_checker.sv
module smb_cfg_checker
  import smb_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_fall,
  input logic                  start_ev,
  input logic                  stop_ev,
  input logic                  sda_oe,
  input logic [NUM_REGS*8-1:0] cfg_regs,
  input smb_state_t            state
);

  // R8: the SDA driver moves only after an SCL fall or a bus condition
  p_oe_moves_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_ev) || $past(stop_ev)))
    else $error("p_oe_moves_on_fall_r8");

  // R3: register contents update only after a byte ends on an SCL fall
  p_regs_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_regs) |-> $past(scl_fall))
    else $error("p_regs_on_fall_r3");

  // R2: an idle slave leaves SDA released
  p_idle_released_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe)
    else $error("p_idle_released_r2");

  // R4: a START puts the slave into address reception with SDA released
  p_start_restarts_r4: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (state == ST_RX && !sda_oe))
    else $error("p_start_restarts_r4");

  // R6: SDA is released while the host answers a read byte
  p_host_ack_slot_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TXACK) |-> !sda_oe)
    else $error("p_host_ack_slot_r6");

endmodule

bind smb_cfg_slave smb_cfg_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_fall (scl_fall),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .sda_oe   (sda_oe),
  .cfg_regs (cfg_regs),
  .state    (state_q)
);

// File: tb/smb_cfg_slave_bench.sv
`timescale 1ns/1ps
module smb_cfg_slave_bench;

  localparam int         NREG = 8;
  localparam int         Q    = 8;
  localparam logic [6:0] ADDR = 7'h69;
  localparam logic [63:0] DEFAULTS = 64'hC300_7EFF_FF10_2481;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_scl = 1'b1;
  logic host_low = 1'b0;
  logic sda_oe;
  logic [NREG*8-1:0] cfg_regs;
  wire  sda_line = ~(host_low | sda_oe);

  int n_cmp = 0;
  int n_bad = 0;
  int r8_viol = 0;
  bit finished = 1'b0;
  logic [7:0] model [NREG];
  logic prev_oe = 1'b0;

  always #2.5 clk = ~clk;

  smb_cfg_slave u_smb_cfg_slave (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (host_scl),
    .sda_i    (sda_line),
    .sda_oe   (sda_oe),
    .cfg_regs (cfg_regs)
  );

  // R8 monitor: SDA drive must hold while SCL is high
  always @(negedge clk) begin
    if (!rst && host_scl && (sda_oe !== prev_oe)) r8_viol++;
    prev_oe = sda_oe;
  end

  function automatic logic [63:0] model_flat();
    logic [63:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  function automatic logic [7:0] model_read(input int off);
    return (off < NREG) ? model[off] : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_low = 1'b0; wq(Q);
    host_scl = 1'b1; wq(Q);
    host_low = 1'b1; wq(Q);
    host_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    host_low = 1'b1; wq(Q);
    host_scl = 1'b1; wq(Q);
    host_low = 1'b0; wq(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      host_low = ~b[i]; wq(Q);
      host_scl = 1'b1; wq(2*Q);
      host_scl = 1'b0; wq(Q);
    end
    host_low = 1'b0; wq(Q);
    host_scl = 1'b1; wq(Q);
    ack = ~sda_line; wq(Q);
    host_scl = 1'b0; wq(Q);
  endtask

  task automatic rbyte(output logic [7:0] b, input logic nack);
    host_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      host_scl = 1'b1; wq(Q);
      b[i] = sda_line; wq(Q);
      host_scl = 1'b0; wq(Q);
    end
    host_low = ~nack; wq(Q);
    host_scl = 1'b1; wq(2*Q);
    host_scl = 1'b0; wq(Q);
    host_low = 1'b0;
  endtask

  task automatic byte_write(input logic [6:0] off, input logic [7:0] d);
    logic a;
    bus_start();
    wbyte({ADDR, 1'b0}, a); chk("R2 address ack", a, 1);
    wbyte({1'b1, off}, a);  chk("R3 command ack", a, 1);
    wbyte(d, a);            chk("R3 data ack", a, 1);
    bus_stop();
    if (off < NREG) model[off] = d;
    chk((off < NREG) ? "R3 bank after byte write" : "R7 write past bank", cfg_regs, model_flat());
  endtask

  task automatic byte_read(input logic [6:0] off);
    logic a;
    logic [7:0] d;
    bus_start();
    wbyte({ADDR, 1'b0}, a); chk("R4 address ack", a, 1);
    wbyte({1'b1, off}, a);  chk("R4 command ack", a, 1);
    bus_start();
    wbyte({ADDR, 1'b1}, a); chk("R4 read address ack", a, 1);
    rbyte(d, 1'b1);
    bus_stop();
    chk((off < NREG) ? "R4 byte read data" : "R7 read past bank", d, model_read(off));
  endtask

  task automatic block_write(input int n);
    logic a;
    logic [7:0] d;
    bus_start();
    wbyte({ADDR, 1'b0}, a); chk("R5 address ack", a, 1);
    wbyte(8'h00, a);        chk("R5 command ack", a, 1);
    wbyte(8'(n), a);        chk("R5 count ack", a, 1);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      wbyte(d, a); chk("R5 block data ack", a, 1);
      if (i < NREG) model[i] = d;
    end
    bus_stop();
    chk((n > NREG) ? "R7 block write past bank" : "R5 bank after block write", cfg_regs, model_flat());
  endtask

  task automatic block_read(input int n);
    logic a;
    logic [7:0] d;
    bus_start();
    wbyte({ADDR, 1'b0}, a); chk("R6 address ack", a, 1);
    wbyte(8'h00, a);        chk("R6 command ack", a, 1);
    bus_start();
    wbyte({ADDR, 1'b1}, a); chk("R6 read address ack", a, 1);
    rbyte(d, n == 0);       chk("R6 count byte", d, NREG);
    for (int i = 0; i < n; i++) begin
      rbyte(d, i == n - 1);
      chk((i < NREG) ? "R6 block read data" : "R7 block read past bank", d, model_read(i));
    end
    wq(2);
    chk("R6 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) model[i] = DEFAULTS[i*8 +: 8];
    repeat (10) @(negedge clk);
    chk("R1 defaults in reset", cfg_regs, DEFAULTS);
    chk("R1 sda released in reset", sda_oe, 0);
    rst = 1'b0;
    wq(5);
    chk("R1 defaults after reset", cfg_regs, DEFAULTS);
    chk("R1 sda released after reset", sda_oe, 0);

    // R2: foreign address, write then read direction
    bus_start();
    wbyte(8'hD0, a); chk("R2 foreign address nack", a, 0);
    wbyte(8'h81, a); chk("R2 no ack after foreign address", a, 0);
    bus_stop();
    chk("R2 bank untouched by foreign write", cfg_regs, model_flat());
    bus_start();
    wbyte(8'hA5, a); chk("R2 foreign read nack", a, 0);
    rbyte(d, 1'b1);  chk("R2 line stays released", d, 8'hFF);
    bus_stop();

    // directed byte accesses
    byte_write(7'd3, 8'hA5);
    byte_read(7'd3);
    byte_write(7'd7, 8'h01);
    byte_read(7'd7);
    byte_read(7'd0);
    byte_write(7'h50, 8'h3C);
    byte_read(7'h50);
    byte_write(7'h08, 8'hEE);
    byte_read(7'h7F);

    // directed block accesses
    block_write(3);
    block_read(8);
    block_write(10);
    block_read(10);
    block_read(0);
    block_write(0);
    block_read(2);

    // random mix
    for (int t = 0; t < 24; t++) begin
      case ($urandom % 4)
        0: byte_write(7'($urandom % 12), 8'($urandom));
        1: byte_read(7'($urandom % 12));
        2: block_write(int'($urandom % 11));
        default: block_read(int'($urandom % 11));
      endcase
    end

    chk("R8 sda moved while scl high", r8_viol, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule